// File: doc/BRIEF.md
# Translation Entry Table Command Engine

This engine services host commands that read and modify a table of address translation entries. A command names a table identifier, a bus address, a value (or, for one command, the address of a list in memory) and a page count. The engine checks the arguments against its configured table: identifier, bus offset, page size (as a shift) and entry count. It then walks the affected entries one page at a time. Entries live in a RAM outside the block, reached through a write port and a read port with one cycle of read latency. List words come through a separate memory read port.

Four operations are supported: write one entry, read one entry, write one value into a run of entries, and write a run of entries whose values are fetched from a list of 64-bit big-endian words. Every entry write raises a one-cycle invalidation notice carrying the page-aligned offset, the page-aligned target and the decoded access permission. This lets downstream translation caches drop stale copies. Each command ends with a one-cycle completion pulse and a success or parameter-error status.

Top module: `xlt_cmd_engine`

## Requirements
- R1: Opcodes on `cmd_op` are 0 = single write, 1 = single read, 2 = fill, 3 = list write. A command is taken only when `busy` is low and `cmd_valid` is high. `busy` rises on the next cycle and stays high through the cycle in which `done` pulses, then falls. A `cmd_valid` seen while `busy` is high has no effect. With no command, the engine makes no table, list or notice activity.
- R2: A command whose identifier has any of bits 63:32 set, or whose bits 31:0 differ from `cfg_tid`, finishes with `status_err` = 1 and writes nothing.
- R3: For a single write, the bus address is first rounded down to a page boundary. The index is then (address − `cfg_bus_off`) >> `cfg_page_shift`. An index at or above `cfg_nentries` (this includes addresses below the offset) gives `status_err` = 1 and no write. Otherwise the value is stored at that index and the status is 0.
- R4: A single read uses the same index rule. On success it returns the stored entry on `get_value` during the `done` cycle with status 0. An out-of-range index gives `status_err` = 1.
- R5: A fill with a page count of zero, or larger than `cfg_nentries`, is rejected with no write. Otherwise the same value is written into successive pages, starting at the rounded start address.
- R6: A list write is rejected if its page count is zero or above 512, or if its list address has any of bits 11:0 set. Otherwise it reads word i at list address + 8·i. Memory byte address A+k is on `mem_rd_data` bits 8k+7:8k, and the word is big-endian (the byte at A is most significant). Word i is written to page i from the rounded start address.
- R7: A fill or list write stops at the first page whose index is out of range. Entries written before that page stay written, and the status is 1.
- R8: Each entry write gives exactly one `note_vld` cycle. `note_iova` is (page address − `cfg_bus_off`), `note_target` is the entry with bits below the page shift cleared, and `note_perm` is entry bits 1:0 (0 none, 1 read-only, 2 write-only, 3 read-write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tid | input | 32 | Identifier of the configured table |
| cfg_bus_off | input | ADDR_W | Bus address of table entry 0 |
| cfg_page_shift | input | SHIFT_W | log2 of the page size |
| cfg_nentries | input | TBL_AW+1 | Number of valid entries |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation code |
| cmd_tid | input | 64 | Table identifier argument |
| cmd_addr | input | ADDR_W | Bus address argument |
| cmd_value | input | ENT_W | Entry value or list address |
| cmd_npages | input | CNT_W | Page count for fill and list write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status_err | output | 1 | Parameter error, valid with done |
| get_value | output | ENT_W | Entry returned by a read |
| tbl_we | output | 1 | Table write enable |
| tbl_waddr | output | TBL_AW | Table write index |
| tbl_wdata | output | ENT_W | Table write data |
| tbl_re | output | 1 | Table read enable |
| tbl_raddr | output | TBL_AW | Table read index |
| tbl_rdata | input | ENT_W | Table read data, one cycle after tbl_re |
| mem_rd_req | output | 1 | List word request pulse |
| mem_rd_addr | output | ENT_W | List word byte address |
| mem_rd_vld | input | 1 | List word response strobe |
| mem_rd_data | input | ENT_W | List word response data |
| note_vld | output | 1 | Invalidation notice strobe |
| note_iova | output | ADDR_W | Page-aligned offset of the written entry |
| note_target | output | ENT_W | Page-aligned target of the written entry |
| note_perm | output | 2 | Decoded permission of the written entry |

## Verification
The hardest situation to reach is a batch that passes every upfront limit but runs off the end of the table partway through. An example is a 512-word list that is accepted yet fails on its seventeenth page, leaving sixteen writes and sixteen notices behind. The stimulus places fill and list starts a few pages before the last entry, with counts that cross it. Both table sizes are swept, and the full table is compared against an arithmetic model after every command. A second command is pulsed while a list write waits on memory with varying response latency, to show that it is dropped.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    typedef enum logic [1:0] {
        OP_PUT  = 2'd0,
        OP_GET  = 2'd1,
        OP_FILL = 2'd2,
        OP_LIST = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RO   = 2'd1,
        PERM_WO   = 2'd2,
        PERM_RW   = 2'd3
    } perm_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_GETW,
        ST_MWAIT,
        ST_DONE
    } st_e;
endpackage

// File: rtl/xlt_be_swap.sv
module xlt_be_swap #(
    parameter int BYTES = 8
) (
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign dout[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
    end
endmodule

// File: rtl/xlt_page_calc.sv
module xlt_page_calc
    import xlt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENT_W   = 64,
    parameter int SHIFT_W = 5,
    parameter int TBL_AW  = 4
) (
    input  logic [ADDR_W-1:0]  page_addr,
    input  logic [ADDR_W-1:0]  bus_off,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [TBL_AW:0]    nentries,
    input  logic [ENT_W-1:0]   entry,
    output logic [ADDR_W-1:0]  amask,
    output logic [ADDR_W-1:0]  psize,
    output logic [TBL_AW-1:0]  idx,
    output logic               in_range,
    output logic [ADDR_W-1:0]  iova,
    output logic [ENT_W-1:0]   target,
    output perm_e              perm
);
    logic [ADDR_W-1:0] diff;
    logic [ADDR_W-1:0] idx_full;
    logic [ENT_W-1:0]  emask;

    always_comb begin
        psize    = ADDR_W'(1) << shift;
        amask    = ~(psize - ADDR_W'(1));
        emask    = ~((ENT_W'(1) << shift) - ENT_W'(1));
        diff     = page_addr - bus_off;
        idx_full = diff >> shift;
        in_range = idx_full < ADDR_W'(nentries);
        idx      = idx_full[TBL_AW-1:0];
        iova     = diff & amask;
        target   = entry & emask;
        perm     = perm_e'(entry[1:0]);
    end
endmodule

// File: rtl/xlt_arg_check.sv
module xlt_arg_check
    import xlt_pkg::*;
#(
    parameter int ENT_W      = 64,
    parameter int CNT_W      = 16,
    parameter int TBL_AW     = 4,
    parameter int LIST_MAX   = 512,
    parameter int LIST_ALIGN = 12
) (
    input  op_e              op,
    input  logic [63:0]      tid,
    input  logic [31:0]      cfg_tid,
    input  logic [CNT_W-1:0] npages,
    input  logic [ENT_W-1:0] list_addr,
    input  logic [TBL_AW:0]  nentries,
    output logic             reject
);
    localparam logic [CNT_W-1:0] LIST_MAX_C = CNT_W'(LIST_MAX);

    logic tid_bad;
    logic cnt_zero;

    always_comb begin
        tid_bad  = (tid[63:32] != 32'd0) || (tid[31:0] != cfg_tid);
        cnt_zero = (npages == '0);
        reject   = tid_bad;
        case (op)
            OP_FILL: reject = tid_bad || cnt_zero
                              || (npages > CNT_W'(nentries));
            OP_LIST: reject = tid_bad || cnt_zero || (npages > LIST_MAX_C)
                              || (list_addr[LIST_ALIGN-1:0] != '0);
            default: reject = tid_bad;
        endcase
    end
endmodule

// File: rtl/xlt_cmd_engine.sv
module xlt_cmd_engine
    import xlt_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ENT_W      = 64,
    parameter int SHIFT_W    = 5,
    parameter int TBL_AW     = 4,
    parameter int CNT_W      = 16,
    parameter int LIST_MAX   = 512,
    parameter int LIST_ALIGN = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        cfg_tid,
    input  logic [ADDR_W-1:0]  cfg_bus_off,
    input  logic [SHIFT_W-1:0] cfg_page_shift,
    input  logic [TBL_AW:0]    cfg_nentries,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [63:0]        cmd_tid,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [ENT_W-1:0]   cmd_value,
    input  logic [CNT_W-1:0]   cmd_npages,
    output logic               busy,
    output logic               done,
    output logic               status_err,
    output logic [ENT_W-1:0]   get_value,
    output logic               tbl_we,
    output logic [TBL_AW-1:0]  tbl_waddr,
    output logic [ENT_W-1:0]   tbl_wdata,
    output logic               tbl_re,
    output logic [TBL_AW-1:0]  tbl_raddr,
    input  logic [ENT_W-1:0]   tbl_rdata,
    output logic               mem_rd_req,
    output logic [ENT_W-1:0]   mem_rd_addr,
    input  logic               mem_rd_vld,
    input  logic [ENT_W-1:0]   mem_rd_data,
    output logic               note_vld,
    output logic [ADDR_W-1:0]  note_iova,
    output logic [ENT_W-1:0]   note_target,
    output logic [1:0]         note_perm
);
    localparam int WORD_BYTES = ENT_W / 8;

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [ENT_W-1:0]  val;
        logic [CNT_W-1:0]  remain;
        logic              err;
        logic [ENT_W-1:0]  res;
    } regs_t;

    regs_t q, d;

    logic [ENT_W-1:0]  list_word;
    logic [ENT_W-1:0]  entry_now;
    logic [ADDR_W-1:0] amask, psize, iova;
    logic [TBL_AW-1:0] idx;
    logic              in_range;
    logic [ENT_W-1:0]  target;
    perm_e             perm;
    logic              reject;

    xlt_be_swap #(.BYTES(WORD_BYTES)) u_swap (
        .din  (mem_rd_data),
        .dout (list_word)
    );

    assign entry_now = (q.st == ST_MWAIT) ? list_word : q.val;

    xlt_page_calc #(
        .ADDR_W(ADDR_W), .ENT_W(ENT_W), .SHIFT_W(SHIFT_W), .TBL_AW(TBL_AW)
    ) u_page (
        .page_addr (q.addr),
        .bus_off   (cfg_bus_off),
        .shift     (cfg_page_shift),
        .nentries  (cfg_nentries),
        .entry     (entry_now),
        .amask     (amask),
        .psize     (psize),
        .idx       (idx),
        .in_range  (in_range),
        .iova      (iova),
        .target    (target),
        .perm      (perm)
    );

    xlt_arg_check #(
        .ENT_W(ENT_W), .CNT_W(CNT_W), .TBL_AW(TBL_AW),
        .LIST_MAX(LIST_MAX), .LIST_ALIGN(LIST_ALIGN)
    ) u_args (
        .op        (op_e'(cmd_op)),
        .tid       (cmd_tid),
        .cfg_tid   (cfg_tid),
        .npages    (cmd_npages),
        .list_addr (cmd_value),
        .nentries  (cfg_nentries),
        .reject    (reject)
    );

    always_comb begin
        d          = q;
        tbl_we     = 1'b0;
        tbl_re     = 1'b0;
        mem_rd_req = 1'b0;
        done       = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.op     = op_e'(cmd_op);
                    d.addr   = cmd_addr & amask;
                    d.val    = cmd_value;
                    d.remain = (op_e'(cmd_op) == OP_PUT || op_e'(cmd_op) == OP_GET)
                               ? CNT_W'(1) : cmd_npages;
                    d.err    = reject;
                    d.st     = reject ? ST_DONE : ST_STEP;
                end
            end
            ST_STEP: begin
                if (!in_range) begin
                    d.err = 1'b1;
                    d.st  = ST_DONE;
                end else begin
                    case (q.op)
                        OP_GET: begin
                            tbl_re = 1'b1;
                            d.st   = ST_GETW;
                        end
                        OP_LIST: begin
                            mem_rd_req = 1'b1;
                            d.st       = ST_MWAIT;
                        end
                        default: begin
                            tbl_we   = 1'b1;
                            d.addr   = q.addr + psize;
                            d.remain = q.remain - CNT_W'(1);
                            d.st     = (q.remain == CNT_W'(1)) ? ST_DONE : ST_STEP;
                        end
                    endcase
                end
            end
            ST_GETW: begin
                d.res = tbl_rdata;
                d.st  = ST_DONE;
            end
            ST_MWAIT: begin
                if (mem_rd_vld) begin
                    tbl_we   = 1'b1;
                    d.addr   = q.addr + psize;
                    d.val    = q.val + ENT_W'(WORD_BYTES);
                    d.remain = q.remain - CNT_W'(1);
                    d.st     = (q.remain == CNT_W'(1)) ? ST_DONE : ST_STEP;
                end
            end
            ST_DONE: begin
                done = 1'b1;
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, op: OP_PUT, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.st != ST_IDLE);
    assign status_err  = q.err;
    assign get_value   = q.res;
    assign tbl_waddr   = idx;
    assign tbl_wdata   = entry_now;
    assign tbl_raddr   = idx;
    assign mem_rd_addr = q.val;
    assign note_vld    = tbl_we;
    assign note_iova   = iova;
    assign note_target = target;
    assign note_perm   = perm;
endmodule

// File: rtl/xlt_cmd_engine_chk.sv
module xlt_cmd_engine_chk #(
    parameter int ENT_W  = 64,
    parameter int TBL_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              busy,
    input logic              done,
    input logic              tbl_we,
    input logic [TBL_AW-1:0] tbl_waddr,
    input logic [ENT_W-1:0]  tbl_wdata,
    input logic              tbl_re,
    input logic [TBL_AW:0]   cfg_nentries,
    input logic              mem_rd_req,
    input logic [ENT_W-1:0]  mem_rd_addr,
    input logic              note_vld,
    input logic [1:0]        note_perm
);
    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    // R1
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R1
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tbl_we && !tbl_re && !mem_rd_req && !note_vld));

    // R3
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> ({1'b0, tbl_waddr} < cfg_nentries));

    // R6
    list_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[2:0] == 3'd0));

    // R8
    note_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        note_vld |-> (tbl_we && (tbl_wdata[1:0] == note_perm)));
endmodule

bind xlt_cmd_engine xlt_cmd_engine_chk #(.ENT_W(ENT_W), .TBL_AW(TBL_AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .busy         (busy),
    .done         (done),
    .tbl_we       (tbl_we),
    .tbl_waddr    (tbl_waddr),
    .tbl_wdata    (tbl_wdata),
    .tbl_re       (tbl_re),
    .cfg_nentries (cfg_nentries),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .note_vld     (note_vld),
    .note_perm    (note_perm)
);

// File: tb/sim_xlt_cmd_engine.sv
`timescale 1ns/1ps
module sim_xlt_cmd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_tid = 32'h42;
    logic [31:0] cfg_bus_off = 32'h0001_0000;
    logic [4:0]  cfg_page_shift = 5'd12;
    logic [4:0]  cfg_nentries = 5'd16;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [63:0] cmd_tid = 64'd0;
    logic [31:0] cmd_addr = 32'd0;
    logic [63:0] cmd_value = 64'd0;
    logic [15:0] cmd_npages = 16'd0;
    logic        busy, done, status_err;
    logic [63:0] get_value;
    logic        tbl_we, tbl_re;
    logic [3:0]  tbl_waddr, tbl_raddr;
    logic [63:0] tbl_wdata;
    logic [63:0] tbl_rdata;
    logic        mem_rd_req;
    logic [63:0] mem_rd_addr;
    logic        mem_rd_vld;
    logic [63:0] mem_rd_data;
    logic        note_vld;
    logic [31:0] note_iova;
    logic [63:0] note_target;
    logic [1:0]  note_perm;

    always #10 clk = ~clk;

    xlt_cmd_engine u0 (.*);

    // table RAM with one cycle of read latency
    logic [63:0] ram [0:15];
    initial for (int i = 0; i < 16; i++) ram[i] = 64'd0;
    always @(posedge clk) begin
        if (tbl_we) ram[tbl_waddr] <= tbl_wdata;
        if (tbl_re) tbl_rdata <= ram[tbl_raddr];
    end

    function automatic logic [63:0] gen_word(input logic [63:0] a);
        return {a[31:0] ^ 32'hC3A5_0F00, ~a[31:0] ^ {a[10:3], 24'h5A_1234}};
    endfunction

    function automatic logic [63:0] raw_word(input logic [63:0] a);
        logic [63:0] g;
        logic [63:0] r;
        g = gen_word(a);
        for (int b = 0; b < 8; b++) r[8*b +: 8] = g[8*(7-b) +: 8];
        return r;
    endfunction

    // list memory with a latency of 0..3 extra cycles
    logic        pend = 1'b0;
    logic [1:0]  lat = 2'd0;
    logic [63:0] paddr = 64'd0;
    initial begin mem_rd_vld = 1'b0; mem_rd_data = 64'd0; tbl_rdata = 64'd0; end
    always @(posedge clk) begin
        mem_rd_vld <= 1'b0;
        if (pend) begin
            if (lat == 2'd0) begin
                mem_rd_vld  <= 1'b1;
                mem_rd_data <= raw_word(paddr);
                pend        <= 1'b0;
            end else begin
                lat <= lat - 2'd1;
            end
        end
        if (mem_rd_req) begin
            pend  <= 1'b1;
            paddr <= mem_rd_addr;
            lat   <= mem_rd_addr[4:3];
        end
    end

    // notice capture
    logic [31:0] a_iova [0:1023];
    logic [63:0] a_tgt  [0:1023];
    logic [1:0]  a_perm [0:1023];
    int n_act = 0;
    int n_done = 0;
    always @(posedge clk) begin
        if (note_vld) begin
            a_iova[n_act[9:0]] <= note_iova;
            a_tgt[n_act[9:0]]  <= note_target;
            a_perm[n_act[9:0]] <= note_perm;
            n_act <= n_act + 1;
        end
        if (done) n_done <= n_done + 1;
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // reference model state
    logic [63:0] m_tbl [0:15];
    logic [31:0] e_iova [0:1023];
    logic [63:0] e_tgt  [0:1023];
    logic [1:0]  e_perm [0:1023];
    int          n_exp;
    bit          e_err;
    logic [63:0] e_get;
    initial for (int i = 0; i < 16; i++) m_tbl[i] = 64'd0;

    task automatic model_cmd(input logic [1:0] op, input logic [63:0] tid,
                             input logic [31:0] addr, input logic [63:0] val,
                             input logic [15:0] np);
        logic [31:0] psz, amsk, a, diff, ix;
        logic [63:0] emsk, e;
        int cnt;
        psz  = 32'd1 << cfg_page_shift;
        amsk = ~(psz - 32'd1);
        emsk = ~((64'd1 << cfg_page_shift) - 64'd1);
        a    = addr & amsk;
        n_exp = 0;
        e_err = (tid[63:32] != 0) || (tid[31:0] != cfg_tid);
        if (op == 2'd2 && (np == 0 || np > {11'd0, cfg_nentries})) e_err = 1'b1;
        if (op == 2'd3 && (np == 0 || np > 16'd512 || val[11:0] != 0)) e_err = 1'b1;
        cnt = (op < 2'd2) ? 1 : int'(np);
        if (!e_err) begin
            for (int i = 0; i < cnt; i++) begin
                diff = a - cfg_bus_off;
                ix   = diff >> cfg_page_shift;
                if (ix >= {27'd0, cfg_nentries}) begin
                    e_err = 1'b1;
                    break;
                end
                if (op == 2'd1) begin
                    e_get = m_tbl[ix[3:0]];
                end else begin
                    e = (op == 2'd3) ? gen_word(val + 64'(8 * i)) : val;
                    m_tbl[ix[3:0]] = e;
                    e_iova[n_exp] = diff & amsk;
                    e_tgt[n_exp]  = e & emsk;
                    e_perm[n_exp] = e[1:0];
                    n_exp++;
                end
                a = a + psz;
            end
        end
    endtask

    task automatic drive_cmd(input logic [1:0] op, input logic [63:0] tid,
                             input logic [31:0] addr, input logic [63:0] val,
                             input logic [15:0] np);
        cmd_valid  = 1'b1;
        cmd_op     = op;
        cmd_tid    = tid;
        cmd_addr   = addr;
        cmd_value  = val;
        cmd_npages = np;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic await_and_compare(input string tag, input int base,
                                     input logic [1:0] op);
        int w = 0;
        while (!done && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk(done == 1'b1, tag, "done seen", {63'd0, done}, 64'd1);
        chk(status_err == e_err, tag, "status", {63'd0, status_err}, {63'd0, e_err});
        if (op == 2'd1 && !e_err)
            chk(get_value == e_get, tag, "read value", get_value, e_get);
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after done", {63'd0, busy}, 64'd0);
        chk(n_act - base == n_exp, tag, "write count",
            64'(n_act - base), 64'(n_exp));
        for (int i = 0; i < n_exp && i < n_act - base; i++) begin
            chk(a_iova[(base + i) % 1024] == e_iova[i], "R8", "notice offset",
                {32'd0, a_iova[(base + i) % 1024]}, {32'd0, e_iova[i]});
            chk(a_tgt[(base + i) % 1024] == e_tgt[i], "R8", "notice target",
                a_tgt[(base + i) % 1024], e_tgt[i]);
            chk(a_perm[(base + i) % 1024] == e_perm[i], "R8", "notice perm",
                {62'd0, a_perm[(base + i) % 1024]}, {62'd0, e_perm[i]});
        end
        for (int i = 0; i < 16; i++)
            chk(ram[i] == m_tbl[i], tag, "table entry", ram[i], m_tbl[i]);
    endtask

    task automatic run(input string tag, input logic [1:0] op, input logic [63:0] tid,
                       input logic [31:0] addr, input logic [63:0] val,
                       input logic [15:0] np);
        int base;
        model_cmd(op, tid, addr, val, np);
        base = n_act;
        drive_cmd(op, tid, addr, val, np);
        await_and_compare(tag, base, op);
    endtask

    function automatic logic [31:0] pg(input int k);
        return cfg_bus_off + 32'(k) * (32'd1 << cfg_page_shift);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1", "reset idle", {63'd0, busy}, 64'd0);
        chk(tbl_we == 1'b0 && mem_rd_req == 1'b0, "R1", "reset quiet",
            {63'd0, tbl_we}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int cfgsel = 0; cfgsel < 2; cfgsel++) begin
            if (cfgsel == 1) begin
                cfg_bus_off = 32'h300; cfg_page_shift = 5'd8; cfg_nentries = 5'd10;
                cfg_tid = 32'h7;
            end
            // R3 single write sweep, unaligned addresses, both sides of the range
            for (int k = -2; k <= 18; k++)
                run("R3", 2'd0, {32'd0, cfg_tid}, pg(k) + 32'((k * 37) & 255),
                    {32'(k) ^ 32'hBEEF_0000, 24'h5, 8'(k)}, 16'd0);
            // R4 single read sweep
            for (int k = -1; k <= 17; k++)
                run("R4", 2'd1, {32'd0, cfg_tid}, pg(k) + 32'(k & 15), 64'd0, 16'd0);
            // R2 identifier checks
            run("R2", 2'd0, {32'd1, cfg_tid}, pg(1), 64'hDEAD, 16'd0);
            run("R2", 2'd0, {32'd0, cfg_tid ^ 32'h1}, pg(1), 64'hDEAD, 16'd0);
            run("R2", 2'd2, {32'h8000_0000, cfg_tid}, pg(0), 64'hDEAD, 16'd2);
            // R5 fills
            run("R5", 2'd2, {32'd0, cfg_tid}, pg(0), 64'h1111_0003, {11'd0, cfg_nentries});
            run("R5", 2'd2, {32'd0, cfg_tid}, pg(2) + 32'd5, 64'h2222_F001, 16'd3);
            run("R5", 2'd2, {32'd0, cfg_tid}, pg(0), 64'h3333_0002,
                {11'd0, cfg_nentries} + 16'd1);
            run("R5", 2'd2, {32'd0, cfg_tid}, pg(0), 64'h4444_0002, 16'd0);
            // R7 fill running off the end
            run("R7", 2'd2, {32'd0, cfg_tid}, pg(int'(cfg_nentries) - 3), 64'h5555_0001, 16'd6);
            // R6 list writes
            run("R6", 2'd3, {32'd0, cfg_tid}, pg(1), 64'h2000, 16'd5);
            run("R6", 2'd3, {32'd0, cfg_tid}, pg(0), 64'h3000, 16'd513);
            run("R6", 2'd3, {32'd0, cfg_tid}, pg(0), 64'h2008, 16'd2);
            run("R6", 2'd3, {32'd0, cfg_tid}, pg(0), 64'h2000, 16'd0);
            // R7 list running off the end, including the largest accepted count
            run("R7", 2'd3, {32'd0, cfg_tid}, pg(int'(cfg_nentries) - 2), 64'h4000, 16'd4);
            run("R7", 2'd3, {32'd0, cfg_tid}, pg(0), 64'h5000, 16'd512);
        end

        // R1: a second command while busy is dropped
        begin
            int base;
            int d0;
            model_cmd(2'd3, {32'd0, cfg_tid}, pg(0), 64'h6000, 16'd4);
            base = n_act;
            d0 = n_done;
            drive_cmd(2'd3, {32'd0, cfg_tid}, pg(0), 64'h6000, 16'd4);
            @(negedge clk);
            chk(busy == 1'b1, "R1", "busy during list", {63'd0, busy}, 64'd1);
            drive_cmd(2'd0, {32'd0, cfg_tid}, pg(8), 64'hFACE_0003, 16'd0);
            await_and_compare("R1", base, 2'd3);
            repeat (5) @(negedge clk);
            chk(n_done - d0 == 1, "R1", "one completion", 64'(n_done - d0), 64'd1);
            chk(n_act - base == n_exp, "R1", "no extra write",
                64'(n_act - base), 64'(n_exp));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule